// File: doc/BRIEF.md
# Local Interrupt Timer with Modes

This block is a per-core timer that requests a single programmable interrupt vector. A small register port sets the mode, the vector, a count prescaler, a start count and an absolute deadline. In the two countdown modes a down-counter runs at the prescaled rate. The one-shot mode stops the counter at zero after one request. The periodic mode reloads the start count each time the counter expires. In deadline mode the counter is idle, and a 64-bit deadline is compared with a free-running timestamp input.

Every expiry produces a one-cycle request pulse, with the programmed vector alongside it. Changing the mode while the counter runs does not reload the counter. An expired deadline clears itself, so software can tell from a read of zero that it has already fired. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `lcl_irq_timer`

## Requirements
- R1: After reset, `irq_req` is low, and every register reads zero: control, start count, current count, divide code and deadline.
- R2: In one-shot mode (mode 0) with divide-by-1, writing a nonzero start count N makes `irq_req` pulse for exactly one cycle, N clocks after the write edge, with `irq_vec` equal to the programmed vector. The current count then stays at zero and no further request follows.
- R3: The divide code uses bits 3, 1 and 0 as a 3-bit value s = {b3,b1,b0}. s = 7 (code 0xB) gives divide-by-1, and any other s gives divide-by-2^(s+1). The counter decrements once per divide period, and the prescaler restarts on every start-count write. A start count N therefore expires N times the divide period after the write.
- R4: In periodic mode (mode 1), the counter reloads the start count on the clock where it expires. It raises a request every N times the divide period.
- R5: Writing the control register to switch between one-shot and periodic leaves the current count and the start-count register unchanged. Counting continues from where it was.
- R6: Once a one-shot countdown has expired, switching to periodic leaves the current count at zero and raises no request.
- R7: In deadline mode (mode 2), a nonzero deadline D fires on the first clock after the write at which the timestamp sampled on that edge is at least D. A deadline at or below the current timestamp therefore fires one clock after the write. After firing, the deadline register reads zero.
- R8: Writing zero to the start count or to the deadline disarms the timer without any request.
- R9: While the mode is deadline, the current count reads zero.
- R10: Register map, by `reg_addr`: 0 is control, with vector in bits 7:0 and mode in bits 9:8 (mode 3 counts as one-shot). 1 is the start count, and 2 is the current count; writes to address 2 are ignored. 3 is the divide code, in bits 3:0, read back with bit 2 as zero. 4 is the deadline. Unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both write and read |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| tstamp | input | 64 | Free-running timestamp compared with the deadline |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vec | output | 8 | Vector sent with the request |

## Verification
The bench builds the block with its default widths: a 32-bit counter, a 64-bit timestamp and an 8-bit vector. With the bench's short start counts and divide codes 0xB, 0x0, 0x1 and 0x9, every countdown, periodic reload and mid-count mode switch completes within a few hundred clocks. The timestamp is a fixed offset plus the bench's own cycle count. Deadlines in the past, in the future and written as zero are therefore placed on exact, predictable edges, and a scoreboard can expect each request at a known cycle.

// File: rtl/lcl_timer_pkg.sv
package lcl_timer_pkg;

  typedef enum logic [1:0] {
    TM_ONCE     = 2'd0,
    TM_PERIOD   = 2'd1,
    TM_DEADLINE = 2'd2,
    TM_RSVD     = 2'd3
  } tm_mode_e;

  localparam logic [2:0] RA_CTRL     = 3'd0;
  localparam logic [2:0] RA_INIT     = 3'd1;
  localparam logic [2:0] RA_CUR      = 3'd2;
  localparam logic [2:0] RA_DIV      = 3'd3;
  localparam logic [2:0] RA_DEADLINE = 3'd4;

  // prescaler must hold a count up to the largest divide period (128)
  localparam int PRE_W = 7;

endpackage

// File: rtl/lcl_timer_prescale.sv
module lcl_timer_prescale
  import lcl_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [2:0] div_sel,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] limit;

  always_comb begin
    if (div_sel == 3'b111) limit = '0;
    else                   limit = PRE_W'((2 << div_sel) - 1);
  end

  assign tick = (pre_q >= limit);

  always_comb begin
    if (clr || tick) pre_d = '0;
    else             pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R3
  prescale_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel != 3'b111) |=> (!tick || div_sel == 3'b111));

endmodule

// File: rtl/lcl_timer_countdown.sv
module lcl_timer_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             reload,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] cur,
  output logic             fire
);

  logic [CNT_W-1:0] cur_q;
  logic [CNT_W-1:0] cur_d;
  logic             step;
  logic             last;

  assign step = run && tick && (cur_q != '0) && !load;
  assign last = (cur_q == CNT_W'(1));
  assign fire = step && last;
  assign cur  = cur_q;

  always_comb begin
    cur_d = cur_q;
    if (load)      cur_d = load_val;
    else if (step) cur_d = last ? (reload ? init_val : '0) : cur_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end

  // R6
  cd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == '0 && !load) |=> (cur_q == '0));

  // R3
  cd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cur_q));

  // R4
  cd_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && reload) |=> (cur_q == $past(init_val)));

endmodule

// File: rtl/lcl_timer_deadline.sv
module lcl_timer_deadline #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            arm_we,
  input  logic [TS_W-1:0] arm_val,
  input  logic [TS_W-1:0] tstamp,
  output logic [TS_W-1:0] dl,
  output logic            fire
);

  logic [TS_W-1:0] dl_q;
  logic [TS_W-1:0] dl_d;

  assign fire = active && !arm_we && (dl_q != '0) && (tstamp >= dl_q);
  assign dl   = dl_q;

  always_comb begin
    dl_d = dl_q;
    if (arm_we)    dl_d = arm_val;
    else if (fire) dl_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dl_q <= '0;
    else        dl_q <= dl_d;
  end

  // R7
  dl_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (dl_q == '0));

  // R8
  dl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !arm_we) |=> $stable(dl_q));

endmodule

// File: rtl/lcl_irq_timer.sv
module lcl_irq_timer
  import lcl_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TS_W  = 64,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [TS_W-1:0]  reg_wdata,
  output logic [TS_W-1:0]  reg_rdata,
  input  logic [TS_W-1:0]  tstamp,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);

  localparam int CTRL_W = VEC_W + 2;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  // register decode
  logic wr_ctrl, wr_init, wr_div, wr_dl;
  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign wr_init = reg_we && (reg_addr == RA_INIT);
  assign wr_div  = reg_we && (reg_addr == RA_DIV);
  assign wr_dl   = reg_we && (reg_addr == RA_DEADLINE);

  logic [VEC_W-1:0] vec_q,  vec_d;
  tm_mode_e         mode_q, mode_d;
  logic [CNT_W-1:0] init_q, init_d;
  logic [2:0]       div_q,  div_d;

  always_comb begin
    vec_d  = vec_q;
    mode_d = mode_q;
    init_d = init_q;
    div_d  = div_q;
    if (wr_ctrl) begin
      vec_d  = reg_wdata[VEC_W-1:0];
      mode_d = tm_mode_e'(reg_wdata[VEC_W+1:VEC_W]);
    end
    if (wr_init) init_d = reg_wdata[CNT_W-1:0];
    if (wr_div)  div_d  = {reg_wdata[3], reg_wdata[1:0]};
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      vec_q  <= '0;
      mode_q <= TM_ONCE;
      init_q <= '0;
      div_q  <= '0;
    end else begin
      vec_q  <= vec_d;
      mode_q <= mode_d;
      init_q <= init_d;
      div_q  <= div_d;
    end
  end

  // datapath
  logic             tick;
  logic             cd_fire, dl_fire;
  logic [CNT_W-1:0] cur;
  logic [TS_W-1:0]  dl;
  logic             run_cnt, reload_cnt;

  assign run_cnt    = (mode_q != TM_DEADLINE);
  assign reload_cnt = (mode_q == TM_PERIOD);

  lcl_timer_prescale u_pre (
    .clk     (clk),
    .rst_n   (rst_l),
    .clr     (wr_init),
    .div_sel (div_q),
    .tick    (tick)
  );

  lcl_timer_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_l),
    .tick     (tick),
    .run      (run_cnt),
    .reload   (reload_cnt),
    .load     (wr_init),
    .load_val (reg_wdata[CNT_W-1:0]),
    .init_val (init_q),
    .cur      (cur),
    .fire     (cd_fire)
  );

  lcl_timer_deadline #(.TS_W(TS_W)) u_dl (
    .clk     (clk),
    .rst_n   (rst_l),
    .active  (mode_q == TM_DEADLINE),
    .arm_we  (wr_dl),
    .arm_val (reg_wdata),
    .tstamp  (tstamp),
    .dl      (dl),
    .fire    (dl_fire)
  );

  // interrupt output stage
  logic             irq_q, irq_d;
  logic [VEC_W-1:0] ivec_q, ivec_d;

  always_comb begin
    irq_d  = cd_fire | dl_fire;
    ivec_d = irq_d ? vec_q : ivec_q;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      irq_q  <= 1'b0;
      ivec_q <= '0;
    end else begin
      irq_q  <= irq_d;
      ivec_q <= ivec_d;
    end
  end

  assign irq_req = irq_q;
  assign irq_vec = ivec_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL:     reg_rdata[CTRL_W-1:0] = {mode_q, vec_q};
      RA_INIT:     reg_rdata[CNT_W-1:0]  = init_q;
      RA_CUR:      reg_rdata[CNT_W-1:0]  = (mode_q == TM_DEADLINE) ? '0 : cur;
      RA_DIV:      reg_rdata[3:0]        = {div_q[2], 1'b0, div_q[1:0]};
      RA_DEADLINE: reg_rdata             = dl;
      default:     reg_rdata             = '0;
    endcase
  end

  // R5
  ctrl_keeps_init_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (wr_ctrl && !wr_init) |=> $stable(init_q));

  // R2
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_l)
    irq_req |-> (irq_vec == $past(vec_q)));

endmodule

// File: tb/lcl_irq_timer_tb_top.sv
module lcl_irq_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic [63:0] tstamp;
  logic        irq_req;
  logic [7:0]  irq_vec;

  always #10 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  assign tstamp = 64'd1000 + 64'(cyc);

  lcl_irq_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tstamp    (tstamp),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;

  typedef struct {
    int unsigned cyc;
    logic [7:0]  vec;
    string       req;
  } exp_t;

  exp_t exp_q[$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_irq(input int unsigned at, input logic [7:0] v, input string req);
    exp_t e;
    e.cyc = at; e.vec = v; e.req = req;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (irq_req === 1'b1) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R2/R6/R8 unexpected request actual=cycle %0d vec %0h expected=none", cyc, irq_vec);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.cyc != cyc || e.vec !== irq_vec) begin
            n_bad++;
            $display("FAIL %s actual=cycle %0d vec %0h expected=cycle %0d vec %0h",
                     e.req, cyc, irq_vec, e.cyc, e.vec);
          end
        end
      end else if (exp_q.size() != 0 && exp_q[0].cyc <= cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        n_bad++;
        $display("FAIL %s actual=no request by cycle %0d expected=cycle %0d vec %0h",
                 e.req, cyc, e.cyc, e.vec);
      end
    end
  end

  // write: returns the bench cycle count seen after the write edge
  task automatic wr(input logic [2:0] a, input logic [63:0] d, output int unsigned wc);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    wc = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] v, output int unsigned rc);
    @(negedge clk);
    reg_addr = a;
    #1;
    v  = reg_rdata;
    rc = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=run not finished expected=finished");
    summary();
    $finish;
  end

  initial begin
    int unsigned c0, rc, k, t;
    logic [63:0] v, dlv;

    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    mon_on = 1'b1;

    // R1 reset state
    chk("R1 irq_req", 64'(irq_req), 64'd0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v, rc);
      chk("R1 register reset", v, 64'd0);
    end

    // R2 one-shot, divide-by-1
    wr(3'd0, 64'h041, c0);
    wr(3'd3, 64'hB, c0);
    rd(3'd3, v, rc);
    chk("R10 divide code readback", v, 64'hB);
    wr(3'd1, 64'd20, c0);
    push_irq(c0 + 20, 8'h41, "R2 one-shot expiry");
    rd(3'd1, v, rc);
    chk("R10 start count readback", v, 64'd20);
    rd(3'd2, v, rc);
    chk("R2 counting value", v, 64'(20 - (rc - c0)));
    idle(30);
    rd(3'd2, v, rc);
    chk("R2 stopped at zero", v, 64'd0);
    wr(3'd2, 64'd55, c0);
    rd(3'd2, v, rc);
    chk("R10 current count write ignored", v, 64'd0);

    // R6 expired one-shot switched to periodic
    wr(3'd0, 64'h141, c0);
    idle(40);
    rd(3'd2, v, rc);
    chk("R6 stays at zero", v, 64'd0);

    // R3 prescaler codes
    wr(3'd0, 64'h042, c0);
    wr(3'd3, 64'h0, c0);
    wr(3'd1, 64'd10, c0);
    push_irq(c0 + 20, 8'h42, "R3 divide-by-2");
    idle(25);
    wr(3'd3, 64'h1, c0);
    wr(3'd1, 64'd5, c0);
    push_irq(c0 + 20, 8'h42, "R3 divide-by-4");
    idle(25);
    wr(3'd3, 64'h9, c0);
    wr(3'd1, 64'd3, c0);
    push_irq(c0 + 192, 8'h42, "R3 divide-by-64");
    idle(100);
    rd(3'd2, v, rc);
    chk("R3 divide-by-64 counting value", v, 64'(3 - (rc - c0) / 64));
    idle(100);

    // R4 periodic, R5 mode switch keeps count
    wr(3'd3, 64'hB, c0);
    wr(3'd0, 64'h143, c0);
    wr(3'd1, 64'd50, c0);
    push_irq(c0 + 50,  8'h43, "R4 periodic first");
    push_irq(c0 + 100, 8'h43, "R4 periodic reload");
    push_irq(c0 + 150, 8'h43, "R5 finish after switch to one-shot");
    while (cyc < c0 + 118) @(negedge clk);
    rd(3'd2, v, rc);
    k = rc - c0;
    chk("R4 value after reload", v, 64'(50 - (k % 50)));
    wr(3'd0, 64'h043, t);
    rd(3'd2, v, rc);
    k = rc - c0;
    chk("R5 count kept on mode switch", v, 64'(50 - (k % 50)));
    rd(3'd1, v, rc);
    chk("R5 start count kept", v, 64'd50);
    while (cyc < c0 + 260) @(negedge clk);
    rd(3'd2, v, rc);
    chk("R5 one-shot stopped at zero", v, 64'd0);

    // R9 current count hidden in deadline mode
    wr(3'd1, 64'd1000, c0);
    wr(3'd0, 64'h244, c0);
    rd(3'd2, v, rc);
    chk("R9 current count reads zero", v, 64'd0);
    rd(3'd0, v, rc);
    chk("R10 control readback", v, 64'h244);
    wr(3'd1, 64'd0, c0);

    // R7 deadline in the past
    wr(3'd4, 64'd5, c0);
    push_irq(c0 + 1, 8'h44, "R7 past deadline");
    idle(4);
    rd(3'd4, v, rc);
    chk("R7 deadline self-cleared", v, 64'd0);

    // R7 deadline in the future
    @(negedge clk);
    dlv = 64'd1000 + 64'(cyc) + 64'd30;
    wr(3'd4, dlv, c0);
    k = 32'(dlv - 64'd1000) - c0 + 1;
    if (int'(k) < 1) k = 1;
    push_irq(c0 + k, 8'h44, "R7 future deadline");
    rd(3'd4, v, rc);
    chk("R7 armed deadline readback", v, dlv);
    idle(40);
    rd(3'd4, v, rc);
    chk("R7 future deadline self-cleared", v, 64'd0);

    // R8 disarm by zero writes
    @(negedge clk);
    dlv = 64'd1000 + 64'(cyc) + 64'd20;
    wr(3'd4, dlv, c0);
    wr(3'd4, 64'd0, c0);
    idle(40);
    rd(3'd4, v, rc);
    chk("R8 deadline disarmed", v, 64'd0);
    wr(3'd0, 64'h045, c0);
    wr(3'd1, 64'd30, c0);
    idle(5);
    wr(3'd1, 64'd0, c0);
    idle(50);
    rd(3'd2, v, rc);
    chk("R8 count disarmed", v, 64'd0);

    chk("R2 all expected requests seen", 64'(exp_q.size()), 64'd0);
    summary();
    $finish;
  end

endmodule